// File: doc/BRIEF.md
# Windowed Wake-Up Pattern Detector

This block sits behind a receiver's chip slicer and decides whether a wake-up has occurred. Each symbol-synchronization pulse starts a new search. After the pulse, the block counts valid chips against a programmed chip budget. In pattern mode it raises a one-cycle wake-up pulse when a programmed 16-chip word appears within that budget. In the two non-pattern modes it wakes once the budget has been consumed.

The comparison shift register must be completely loaded before any comparison is allowed. A comparison is made when a valid chip arrives, against the 16 chips already held, so the earliest possible match lands on chip 17. A zero budget has two meanings. It wakes at once in the non-pattern modes and can never wake in pattern mode. When a search ends without a wake-up, the block raises a window-expired flag. The flag holds until the next synchronization pulse, and chips that arrive in the meantime are ignored.

Top module: `wake_pattern_scan`

## Requirements
- R1: After reset, `wake_pulse` and `win_expired` are 0, and no wake-up occurs until a `sym_sync` pulse has been seen.
- R2: A `sym_sync` pulse clears the shift register, the fill count and the chip count, and arms a new search. A chip presented in the same cycle as `sym_sync` is not counted.
- R3: Only cycles with `chip_vld` high advance the search. Cycles with `chip_vld` low change nothing.
- R4: Each valid chip enters the LSB of the 16-bit shift register. The first chip received after sync therefore ends up in bit 15. The pattern is {`pat_hi`,`pat_lo`}, with `pat_hi[7]` as bit 15.
- R5: In pattern mode, a valid chip triggers a comparison of the 16 chips held before it, and only when all 16 are loaded. The earliest wake-up is therefore on chip 17, and a budget below 17 can never wake.
- R6: In pattern mode, chip number n (counted from 1 after sync) can trigger a wake-up only if n ≤ `win_cnt`.
- R7: When the chip that reaches `win_cnt` brings no wake-up in pattern mode, `win_expired` rises in the following cycle. It stays high, and further chips are ignored, until the next `sym_sync`.
- R8: In pattern mode (`mode[1]`=1), `win_cnt`=0 gives no wake-up. `win_expired` rises one cycle after `sym_sync`.
- R9: In the random mode (`mode`=00) or the equal mode (`mode`=01), `win_cnt`=0 gives a `wake_pulse` in the cycle after `sym_sync`.
- R10: In the non-pattern modes with a nonzero `win_cnt`, `wake_pulse` rises in the cycle after the valid chip numbered `win_cnt`, and not before.
- R11: `wake_pulse` lasts one cycle. At most one wake-up occurs per `sym_sync`. `wake_pulse` and `win_expired` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_vld | input | 1 | Strobe marking a valid chip on `chip_bit` |
| chip_bit | input | 1 | Received chip value |
| sym_sync | input | 1 | One-cycle symbol-synchronization pulse that starts a search |
| pat_hi | input | 8 | Pattern chips 15..8, bit 7 = chip bit 15 |
| pat_lo | input | 8 | Pattern chips 7..0 |
| win_cnt | input | 7 | Chip budget after sync, 0 to 127 |
| mode | input | 2 | 00 random, 01 equal, 1x pattern detection |
| wake_pulse | output | 1 | One-cycle wake-up indication |
| win_expired | output | 1 | Search ended without wake-up; held until next sync |

## Verification
A fill count that advances too early shows up as a wake-up on chip 16 or earlier. A fill count that sticks shows up as a missing wake-up on chip 17. Either fault is visible in the cycle after the chip concerned. A chip counter that is off by one moves the expiry or the non-pattern wake-up by exactly one valid chip. The bench therefore steps chip by chip across the budget boundaries of 16/17 and n/n+1. A search that stays armed after it has ended shows up as a second wake-up or a dropped expiry flag on the chips that follow, and the bench feeds extra chips after every completed search to catch this.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    MODE_RANDOM  = 2'b00,
    MODE_EQUAL   = 2'b01,
    MODE_PATTERN = 2'b10,
    MODE_PAT_ALT = 2'b11
  } wps_mode_e;

  // Pattern comparison applies whenever the upper mode bit is set.
  function automatic logic is_pattern_mode(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/wps_shifter.sv
module wps_shifter #(
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             din,
  output logic [PAT_W-1:0] shreg,
  output logic             full
);
  localparam int FILL_W = $clog2(PAT_W + 1);

  logic [FILL_W-1:0] fill_q;

  // Saturating fill step: stops at the register depth.
  function automatic logic [FILL_W-1:0] fill_step(input logic [FILL_W-1:0] f);
    if (f == FILL_W'(PAT_W)) return f;
    return f + FILL_W'(1);
  endfunction

  // Flop chain, one stage per chip position.
  genvar gi;
  generate
    for (gi = 0; gi < PAT_W; gi++) begin : g_stage
      logic src;
      if (gi == 0) begin : g_head
        assign src = din;
      end else begin : g_body
        assign src = shreg[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     shreg[gi] <= 1'b0;
        else if (clear) shreg[gi] <= 1'b0;
        else if (shift) shreg[gi] <= src;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fill_q <= '0;
    else if (clear) fill_q <= '0;
    else if (shift) fill_q <= fill_step(fill_q);
  end

  assign full = (fill_q == FILL_W'(PAT_W));
endmodule

// File: rtl/wps_window.sv
module wps_window #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] budget,
  output logic             last,
  output logic             zero_budget
);
  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (step)  count_q <= count_next(count_q);
  end

  // The chip being taken now is the one that meets the budget.
  assign last        = step && (count_next(count_q) == budget);
  assign zero_budget = (budget == '0);
endmodule

// File: rtl/wps_ctrl.sv
module wps_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sync,
  input  logic chip_vld,
  input  logic pat_mode,
  input  logic zero_budget,
  input  logic cmp_ready,
  input  logic pat_eq,
  input  logic win_last,
  output logic armed,
  output logic chip_evt,
  output logic wake_pulse,
  output logic win_expired
);
  logic pat_hit, wake_set, exp_set, armed_n, expired_n;

  assign chip_evt = chip_vld && armed && !sync;
  assign pat_hit  = cmp_ready && pat_eq;

  always_comb begin
    if (sync) begin
      wake_set  = zero_budget && !pat_mode;
      exp_set   = zero_budget && pat_mode;
      armed_n   = !zero_budget;
      expired_n = exp_set;
    end else begin
      wake_set  = chip_evt && (pat_mode ? pat_hit : win_last);
      exp_set   = chip_evt && pat_mode && !pat_hit && win_last;
      armed_n   = armed && !wake_set && !exp_set;
      expired_n = win_expired || exp_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      wake_pulse  <= 1'b0;
      win_expired <= 1'b0;
    end else begin
      armed       <= armed_n;
      wake_pulse  <= wake_set;
      win_expired <= expired_n;
    end
  end
endmodule

// File: rtl/wake_pattern_scan.sv
module wake_pattern_scan
  import wps_pkg::*;
#(
  parameter int PAT_W = 16,
  parameter int CNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chip_vld,
  input  logic               chip_bit,
  input  logic               sym_sync,
  input  logic [PAT_W/2-1:0] pat_hi,
  input  logic [PAT_W/2-1:0] pat_lo,
  input  logic [CNT_W-1:0]   win_cnt,
  input  logic [1:0]         mode,
  output logic               wake_pulse,
  output logic               win_expired
);
  logic [PAT_W-1:0] shreg;
  logic [PAT_W-1:0] pattern;
  logic             pat_mode, cmp_ready, pat_eq, win_last, zero_budget;
  logic             armed, chip_evt;

  assign pattern  = {pat_hi, pat_lo};
  assign pat_mode = is_pattern_mode(mode);
  assign pat_eq   = (shreg == pattern);

  wps_shifter #(.PAT_W(PAT_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (sym_sync),
    .shift (chip_evt),
    .din   (chip_bit),
    .shreg (shreg),
    .full  (cmp_ready)
  );

  wps_window #(.CNT_W(CNT_W)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (sym_sync),
    .step        (chip_evt),
    .budget      (win_cnt),
    .last        (win_last),
    .zero_budget (zero_budget)
  );

  wps_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync        (sym_sync),
    .chip_vld    (chip_vld),
    .pat_mode    (pat_mode),
    .zero_budget (zero_budget),
    .cmp_ready   (cmp_ready),
    .pat_eq      (pat_eq),
    .win_last    (win_last),
    .armed       (armed),
    .chip_evt    (chip_evt),
    .wake_pulse  (wake_pulse),
    .win_expired (win_expired)
  );
endmodule

// File: rtl/wps_checker.sv
module wps_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sym_sync,
  input logic [CNT_W-1:0] win_cnt,
  input logic [1:0]       mode,
  input logic             armed,
  input logic             chip_evt,
  input logic             cmp_ready,
  input logic             wake_pulse,
  input logic             win_expired
);
  // R11: a wake-up does not repeat unless a fresh sync re-arms
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && !sym_sync) |=> !wake_pulse);

  // R11: the two outcomes exclude each other
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_pulse && win_expired));

  // R7: expiry holds until the next sync
  a_r7_expired_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (win_expired && !sym_sync) |=> win_expired);

  // R5: no pattern wake before the register is loaded
  a_r5_no_early_match: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_evt && mode[1] && !cmp_ready) |=> !wake_pulse);

  // R9: zero budget in non-pattern modes wakes immediately
  a_r9_zero_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_sync && win_cnt == '0 && !mode[1]) |=> wake_pulse);

  // R8: zero budget in pattern mode never wakes and expires
  a_r8_zero_expires: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_sync && win_cnt == '0 && mode[1]) |=> (!wake_pulse && win_expired));

  // R1, R7: an idle search produces no wake-up
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !sym_sync) |=> !wake_pulse);
endmodule

bind wake_pattern_scan wps_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sym_sync    (sym_sync),
  .win_cnt     (win_cnt),
  .mode        (mode),
  .armed       (armed),
  .chip_evt    (chip_evt),
  .cmp_ready   (cmp_ready),
  .wake_pulse  (wake_pulse),
  .win_expired (win_expired)
);

// File: tb/wake_pattern_scan_tb.sv
module wake_pattern_scan_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_vld = 1'b0, chip_bit = 1'b0, sym_sync = 1'b0;
  logic [7:0] pat_hi = 8'h00, pat_lo = 8'h00;
  logic [6:0] win_cnt = 7'd0;
  logic [1:0] mode = 2'b00;
  logic       wake_pulse, win_expired;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  wake_pattern_scan u_dut (
    .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .chip_bit(chip_bit),
    .sym_sync(sym_sync), .pat_hi(pat_hi), .pat_lo(pat_lo), .win_cnt(win_cnt),
    .mode(mode), .wake_pulse(wake_pulse), .win_expired(win_expired)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Inputs change at a negedge; outputs are read at the next negedge.
  task automatic chip(input logic b);
    chip_vld = 1'b1; chip_bit = b;
    @(negedge clk);
    chip_vld = 1'b0;
  endtask

  task automatic sync();
    sym_sync = 1'b1;
    @(negedge clk);
    sym_sync = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends the 16 pattern chips MSB first; none may wake.
  task automatic send_pattern(input string req, output int early);
    early = 0;
    for (int i = 15; i >= 0; i--) begin
      chip({pat_hi, pat_lo}[i]);
      if (wake_pulse) early++;
    end
    check(req, early, 0);
  endtask

  task automatic t_reset();
    check("R1 wake after reset", wake_pulse, 0);
    check("R1 expired after reset", win_expired, 0);
    mode = 2'b00; win_cnt = 7'd1;
    chip(1'b1);
    check("R1 no wake before any sync", wake_pulse, 0);
  endtask

  task automatic t_match17();
    int e;
    mode = 2'b10; pat_hi = 8'hC3; pat_lo = 8'hA6; win_cnt = 7'd20;
    sync();
    send_pattern("R5 no wake within first 16 chips", e);
    chip(1'b0);
    check("R5 wake on chip 17", wake_pulse, 1);
    check("R11 no expiry with wake", win_expired, 0);
    chip(1'b0);
    check("R11 pulse lasts one cycle", wake_pulse, 0);
    for (int i = 15; i >= 0; i--) begin
      chip({pat_hi, pat_lo}[i]);
      if (wake_pulse) e++;
    end
    chip(1'b1);
    check("R11 single wake per sync", e + wake_pulse, 0);
  endtask

  task automatic t_budget16();
    int e;
    mode = 2'b11; pat_hi = 8'hC3; pat_lo = 8'hA6; win_cnt = 7'd16;
    sync();
    send_pattern("R5 budget 16 never wakes", e);
    check("R7 expired after chip 16", win_expired, 1);
    chip(1'b0);
    check("R7 chips ignored after expiry", wake_pulse, 0);
    check("R7 expired holds", win_expired, 1);
  endtask

  task automatic t_late_window();
    int e;
    mode = 2'b10; pat_hi = 8'hA5; pat_lo = 8'h3C; win_cnt = 7'd22;
    sync();
    repeat (5) chip(1'b0);
    send_pattern("R4 no early match on junk prefix", e);
    chip(1'b1);
    check("R4 MSB-first pattern wakes on chip 22", wake_pulse, 1);
    win_cnt = 7'd21;
    sync();
    check("R2 sync clears expiry/wake", win_expired, 0);
    repeat (5) chip(1'b0);
    send_pattern("R6 no wake in window 21", e);
    check("R6 expired at chip 21", win_expired, 1);
    chip(1'b1);
    check("R6 match beyond window ignored", wake_pulse, 0);
  endtask

  task automatic t_zero_pattern();
    int e;
    mode = 2'b10; pat_hi = 8'h00; pat_lo = 8'h00; win_cnt = 7'd0;
    sync();
    check("R8 zero budget pattern no wake", wake_pulse, 0);
    check("R8 zero budget pattern expires", win_expired, 1);
    e = 0;
    repeat (20) begin chip(1'b0); if (wake_pulse) e++; end
    check("R8 zero pattern chips never wake", e, 0);
  endtask

  task automatic t_zero_other();
    mode = 2'b00; win_cnt = 7'd0;
    sync();
    check("R9 random mode zero budget wakes", wake_pulse, 1);
    idle(1);
    check("R11 zero-budget pulse one cycle", wake_pulse, 0);
    mode = 2'b01;
    sync();
    check("R9 equal mode zero budget wakes", wake_pulse, 1);
    check("R9 no expiry", win_expired, 0);
  endtask

  task automatic t_count_other();
    int e;
    mode = 2'b01; win_cnt = 7'd5;
    sync();
    e = 0;
    repeat (4) begin chip(1'b1); if (wake_pulse) e++; end
    check("R10 no wake before chip 5", e, 0);
    chip(1'b0);
    check("R10 wake after chip 5", wake_pulse, 1);
    e = 0;
    repeat (6) begin chip(1'b1); if (wake_pulse || win_expired) e++; end
    check("R11 no second wake / no expiry", e, 0);
    mode = 2'b00; win_cnt = 7'd3;
    sync();
    chip(1'b1); idle(3); chip(1'b0); idle(2);
    check("R3 idle cycles not counted", wake_pulse, 0);
    chip(1'b1);
    check("R3 wake on third valid chip", wake_pulse, 1);
  endtask

  task automatic t_resync();
    int e;
    mode = 2'b10; pat_hi = 8'h5A; pat_lo = 8'hF1; win_cnt = 7'd40;
    sync();
    send_pattern("R2 first partial stream", e);
    sync();
    chip(1'b1);
    check("R2 sync clears loaded register", wake_pulse, 0);
    sync();
    sym_sync = 1'b1; chip(1'b1); sym_sync = 1'b0;
    send_pattern("R2 chip with sync not counted", e);
    chip(1'b0);
    check("R2 wake on chip 17 after sync", wake_pulse, 1);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_match17();
    t_budget16();
    t_late_window();
    t_zero_pattern();
    t_zero_other();
    t_count_other();
    t_resync();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule